// File: doc/BRIEF.md
# Vector Lane Predicate Mask Generator

This block turns four independent masking sources into one 16-bit byte-lane enable mask for a vector instruction that executes in four beats. The sources are the per-lane predicate bits, a mask-enable field for each half of the vector, the tail cut-off on the last iteration of a loop, and skipping of beats that an interrupted instruction already completed. A 1 in the result marks a lane that the instruction may update.

The block is purely combinational. A consumer working on bytes uses all 16 bits. One working on halfwords looks only at the even bits, and one working on words looks only at bits 0, 4, 8 and 12. The executed-beats code is interpreted only when the conditional-execution field is zero. A reserved code drops `beat_code_valid`, and the mask is then meaningless. Raising a fault on that condition is left to the surrounding logic. The block carries no data stream, so it has no valid/ready handshake. All pins are plain control pins.

Top module: `lane_pred_mask`

## Requirements
- R1: With both half-enable fields nonzero, no tail cut and no skipped beats, `lane_mask` equals `pred_bits`.
- R2: When `half_en_lo` is zero, bits 7:0 of the mask before tail and beat masking are all 1. When `half_en_hi` is zero, bits 15:8 are all 1.
- R3: Tail cutting is active when `tail_size` < 4 and `loop_count` <= 1 << (4 - `tail_size`). In that case, only the lowest (`loop_count` << `tail_size`) lanes may stay set, and a loop count of zero clears every lane.
- R4: A `tail_size` of 4 to 7, or a loop count above the limit in R3, clears no lane.
- R5: When `cond_field` is 0, `beat_code` 1 clears lanes 3:0, code 2 clears lanes 7:0, codes 4 and 5 clear lanes 11:0, and code 0 clears nothing.
- R6: When `cond_field` is 0, codes 3, 6 and 7 drive `beat_code_valid` low. Every other code drives it high.
- R7: When `cond_field` is nonzero, `beat_code` has no effect on the mask, and `beat_code_valid` is high.
- R8: The sources combine by AND. A lane is set only if the predicate or half-enable stage, the tail stage and the beat stage all allow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pred_bits | input | 16 | Per-lane predicate bits |
| half_en_lo | input | 4 | Predicate enable field for lanes 7:0 (zero forces them on) |
| half_en_hi | input | 4 | Predicate enable field for lanes 15:8 (zero forces them on) |
| tail_size | input | 3 | Log2 of element size for tail cutting; 4 or more disables it |
| loop_count | input | 32 | Remaining loop element count |
| cond_field | input | 4 | Low conditional-execution bits; zero enables beat skipping |
| beat_code | input | 3 | Executed-beats code |
| lane_mask | output | 16 | Active-lane mask, 1 = active |
| beat_code_valid | output | 1 | Low when a reserved beat code is interpreted |

## Verification
The hardest situation to reach is the one where all four sources cut lanes at once, so that every stage has to be shown to use AND rather than override the others. The vector table includes entries in which the predicate, the tail limit and a skipped-beat code each remove different lanes. It also covers the exact tail boundaries, where the loop count equals the limit or exceeds it by one. Directed loops then sweep every beat code with the conditional field zero and nonzero, and every oversize `tail_size` value.

// File: rtl/lane_pred_pkg.sv
package lane_pred_pkg;
  typedef enum logic [2:0] {
    BEATS_NONE  = 3'd0,
    BEATS_ONE   = 3'd1,
    BEATS_TWO   = 3'd2,
    BEATS_THREE = 3'd4,
    BEATS_CARRY = 3'd5
  } beat_code_e;

  // Number of completed beats a code stands for; reserved codes report none.
  function automatic logic [2:0] beats_done(input logic [2:0] code);
    case (code)
      BEATS_ONE:               return 3'd1;
      BEATS_TWO:               return 3'd2;
      BEATS_THREE, BEATS_CARRY: return 3'd3;
      default:                 return 3'd0;
    endcase
  endfunction

  function automatic logic code_is_legal(input logic [2:0] code);
    case (code)
      BEATS_NONE, BEATS_ONE, BEATS_TWO, BEATS_THREE, BEATS_CARRY: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/lpm_half_force.sv
module lpm_half_force #(
  parameter int LANES   = 16,
  parameter int FIELD_W = 4
) (
  input  logic [LANES-1:0]   pred_in,
  input  logic [FIELD_W-1:0] en_lo,
  input  logic [FIELD_W-1:0] en_hi,
  output logic [LANES-1:0]   pred_out
);
  localparam int HALF = LANES / 2;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i < HALF) begin : g_lo
      assign pred_out[i] = pred_in[i] | (en_lo == '0);
    end else begin : g_hi
      assign pred_out[i] = pred_in[i] | (en_hi == '0);
    end
  end
endmodule

// File: rtl/lpm_tail_cut.sv
module lpm_tail_cut #(
  parameter int LANES  = 16,
  parameter int SIZE_W = 3,
  parameter int LOOP_W = 32
) (
  input  logic [SIZE_W-1:0] size_code,
  input  logic [LOOP_W-1:0] loop_cnt,
  output logic [LANES-1:0]  keep
);
  localparam int LOG2_LANES = $clog2(LANES);

  logic              size_ok;
  logic [SIZE_W-1:0] shamt;
  logic [LOOP_W-1:0] limit;
  logic [LOOP_W-1:0] len;
  logic              active;

  always_comb begin
    size_ok = size_code < SIZE_W'(LOG2_LANES);
    shamt   = size_ok ? (SIZE_W'(LOG2_LANES) - size_code) : '0;
    limit   = LOOP_W'(1) << shamt;
    len     = loop_cnt << size_code;
    active  = size_ok && (loop_cnt <= limit);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign keep[i] = !active || (LOOP_W'(i) < len);
  end
endmodule

// File: rtl/lpm_beat_skip.sv
module lpm_beat_skip
  import lane_pred_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int BEATS  = 4,
  parameter int COND_W = 4
) (
  input  logic [COND_W-1:0] cond,
  input  logic [2:0]        code,
  output logic [LANES-1:0]  keep,
  output logic              valid
);
  localparam int BEAT_LANES = LANES / BEATS;

  logic       skip_on;
  logic [2:0] done;

  always_comb begin
    skip_on = (cond == '0);
    done    = skip_on ? beats_done(code) : 3'd0;
    valid   = !skip_on || code_is_legal(code);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign keep[i] = (3'(i / BEAT_LANES) >= done);
  end
endmodule

// File: rtl/lane_pred_mask.sv
module lane_pred_mask #(
  parameter int LANES   = 16,
  parameter int FIELD_W = 4,
  parameter int SIZE_W  = 3,
  parameter int LOOP_W  = 32,
  parameter int COND_W  = 4
) (
  input  logic [LANES-1:0]   pred_bits,
  input  logic [FIELD_W-1:0] half_en_lo,
  input  logic [FIELD_W-1:0] half_en_hi,
  input  logic [SIZE_W-1:0]  tail_size,
  input  logic [LOOP_W-1:0]  loop_count,
  input  logic [COND_W-1:0]  cond_field,
  input  logic [2:0]         beat_code,
  output logic [LANES-1:0]   lane_mask,
  output logic               beat_code_valid
);
  logic [LANES-1:0] pred_forced;
  logic [LANES-1:0] tail_keep;
  logic [LANES-1:0] beat_keep;

  lpm_half_force #(.LANES(LANES), .FIELD_W(FIELD_W)) u_half (
    .pred_in (pred_bits),
    .en_lo   (half_en_lo),
    .en_hi   (half_en_hi),
    .pred_out(pred_forced)
  );

  lpm_tail_cut #(.LANES(LANES), .SIZE_W(SIZE_W), .LOOP_W(LOOP_W)) u_tail (
    .size_code(tail_size),
    .loop_cnt (loop_count),
    .keep     (tail_keep)
  );

  lpm_beat_skip #(.LANES(LANES), .BEATS(4), .COND_W(COND_W)) u_beat (
    .cond (cond_field),
    .code (beat_code),
    .keep (beat_keep),
    .valid(beat_code_valid)
  );

  assign lane_mask = pred_forced & tail_keep & beat_keep;
endmodule

// File: rtl/lane_pred_mask_chk.sv
module lane_pred_mask_chk #(
  parameter int LANES   = 16,
  parameter int FIELD_W = 4,
  parameter int SIZE_W  = 3,
  parameter int LOOP_W  = 32,
  parameter int COND_W  = 4
) (
  input logic [LANES-1:0]   pred_bits,
  input logic [FIELD_W-1:0] half_en_lo,
  input logic [FIELD_W-1:0] half_en_hi,
  input logic [SIZE_W-1:0]  tail_size,
  input logic [LOOP_W-1:0]  loop_count,
  input logic [COND_W-1:0]  cond_field,
  input logic [2:0]         beat_code,
  input logic [LANES-1:0]   lane_mask,
  input logic               beat_code_valid
);
  always_comb begin
    // R7
    cond_set_valid_chk: assert (cond_field == '0 || beat_code_valid);
    // R6
    reserved_flag_chk: assert (!(cond_field == '0 && (beat_code == 3'd3 || beat_code >= 3'd6))
                               || !beat_code_valid);
    // R5
    three_beats_chk: assert (!(cond_field == '0 && (beat_code == 3'd4 || beat_code == 3'd5))
                             || lane_mask[11:0] == '0);
    // R3
    zero_loop_chk: assert (!(tail_size < 3'd4 && loop_count == '0) || lane_mask == '0);
    // R8
    pred_bound_chk: assert (half_en_lo == '0 || half_en_hi == '0 || (lane_mask & ~pred_bits) == '0);
    // R4
    no_tail_chk: assert (!(tail_size >= 3'd4 && cond_field != '0 && half_en_lo == '0
                           && half_en_hi == '0) || lane_mask == '1);
  end
endmodule

bind lane_pred_mask lane_pred_mask_chk #(
  .LANES(LANES), .FIELD_W(FIELD_W), .SIZE_W(SIZE_W), .LOOP_W(LOOP_W), .COND_W(COND_W)
) u_chk (.*);

// File: tb/sim_lane_pred_mask.sv
module sim_lane_pred_mask;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;
  // {pred16, lo4, hi4, size3, loop32, cond4, code3, exp16, expv1}
  localparam logic [82:0] TBL [NV] = '{
    {16'h1234, 4'h8, 4'h8, 3'd4, 32'd0,  4'h0, 3'd0, 16'h1234, 1'b1}, // R1
    {16'hA5C3, 4'h4, 4'h2, 3'd5, 32'd3,  4'h0, 3'd0, 16'hA5C3, 1'b1}, // R1
    {16'h1234, 4'h0, 4'h0, 3'd4, 32'd0,  4'h0, 3'd0, 16'hFFFF, 1'b1}, // R2
    {16'h1234, 4'h8, 4'h0, 3'd4, 32'd0,  4'h0, 3'd0, 16'hFF34, 1'b1}, // R2
    {16'h1234, 4'h0, 4'h4, 3'd4, 32'd0,  4'h0, 3'd0, 16'h12FF, 1'b1}, // R2
    {16'hA5A5, 4'h0, 4'h0, 3'd0, 32'd5,  4'h0, 3'd0, 16'h001F, 1'b1}, // R3
    {16'hFFFF, 4'h8, 4'h8, 3'd1, 32'd3,  4'h0, 3'd0, 16'h003F, 1'b1}, // R3
    {16'hFFFF, 4'h8, 4'h8, 3'd2, 32'd2,  4'h0, 3'd0, 16'h00FF, 1'b1}, // R3
    {16'hFFFF, 4'h8, 4'h8, 3'd2, 32'd4,  4'h0, 3'd0, 16'hFFFF, 1'b1}, // R3 at limit
    {16'hFFFF, 4'h8, 4'h8, 3'd3, 32'd1,  4'h0, 3'd0, 16'h00FF, 1'b1}, // R3
    {16'hFFFF, 4'h8, 4'h8, 3'd0, 32'd16, 4'h0, 3'd0, 16'hFFFF, 1'b1}, // R3 at limit
    {16'hFFFF, 4'h8, 4'h8, 3'd0, 32'd0,  4'h0, 3'd0, 16'h0000, 1'b1}, // R3 zero
    {16'hFFFF, 4'h8, 4'h8, 3'd0, 32'd17, 4'h0, 3'd0, 16'hFFFF, 1'b1}, // R4
    {16'hFFFF, 4'h8, 4'h8, 3'd2, 32'd5,  4'h0, 3'd0, 16'hFFFF, 1'b1}, // R4
    {16'hFFFF, 4'h8, 4'h8, 3'd4, 32'd0,  4'h0, 3'd1, 16'hFFF0, 1'b1}, // R5
    {16'hFFFF, 4'h8, 4'h8, 3'd4, 32'd0,  4'h0, 3'd2, 16'hFF00, 1'b1}, // R5
    {16'hFFFF, 4'h8, 4'h8, 3'd4, 32'd0,  4'h0, 3'd4, 16'hF000, 1'b1}, // R5
    {16'hFFFF, 4'h8, 4'h8, 3'd4, 32'd0,  4'h0, 3'd5, 16'hF000, 1'b1}, // R5
    {16'hFFFF, 4'h8, 4'h8, 3'd4, 32'd0,  4'h8, 3'd2, 16'hFFFF, 1'b1}, // R7
    {16'hFFFF, 4'h8, 4'h8, 3'd1, 32'd7,  4'h0, 3'd1, 16'h3FF0, 1'b1}, // R8
    {16'hF0F0, 4'h8, 4'h8, 3'd2, 32'd3,  4'h0, 3'd1, 16'h00F0, 1'b1}, // R8
    {16'h5A5A, 4'h8, 4'h0, 3'd2, 32'd3,  4'h0, 3'd2, 16'h0F00, 1'b1}  // R8
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pred_bits;
  logic [3:0]  half_en_lo, half_en_hi, cond_field;
  logic [2:0]  tail_size, beat_code;
  logic [31:0] loop_count;
  logic [15:0] lane_mask;
  logic        beat_code_valid;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_pred_mask u0 (
    .pred_bits(pred_bits), .half_en_lo(half_en_lo), .half_en_hi(half_en_hi),
    .tail_size(tail_size), .loop_count(loop_count), .cond_field(cond_field),
    .beat_code(beat_code), .lane_mask(lane_mask), .beat_code_valid(beat_code_valid)
  );

  task automatic apply(input logic [15:0] p, input logic [3:0] lo, input logic [3:0] hi,
                       input logic [2:0] sz, input logic [31:0] lc, input logic [3:0] cf,
                       input logic [2:0] bc);
    @(posedge clk);
    pred_bits = p; half_en_lo = lo; half_en_hi = hi; tail_size = sz;
    loop_count = lc; cond_field = cf; beat_code = bc;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] em, input logic ev, input bit mask_matters);
    total++;
    if ((mask_matters && lane_mask !== em) || beat_code_valid !== ev) begin
      bad++;
      $display("FAIL %s: mask=%h valid=%b expected mask=%h valid=%b", req, lane_mask,
               beat_code_valid, em, ev);
    end
  endtask

  initial begin
    pred_bits = '0; half_en_lo = '0; half_en_hi = '0; tail_size = 3'd4;
    loop_count = '0; cond_field = 4'h1; beat_code = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 reset idle", 16'hFFFF, 1'b1, 1'b1);
    for (int i = 0; i < NV; i++) begin
      apply(TBL[i][82:67], TBL[i][66:63], TBL[i][62:59], TBL[i][58:56], TBL[i][55:24],
            TBL[i][23:20], TBL[i][19:17]);
      check($sformatf("R1-table entry %0d", i), TBL[i][16:1], TBL[i][0], 1'b1);
    end
    // R6: reserved codes with beat skipping enabled
    for (int c = 3; c < 8; c++) begin
      if (c == 4 || c == 5) continue;
      apply(16'hFFFF, 4'h8, 4'h8, 3'd4, 32'd0, 4'h0, 3'(c));
      check("R6 reserved", 16'h0, 1'b0, 1'b0);
    end
    // R7: every code ignored while inside a conditional block
    for (int c = 0; c < 8; c++) begin
      apply(16'h6C39, 4'h2, 4'h8, 3'd4, 32'd0, 4'h4, 3'(c));
      check("R7 ignored", 16'h6C39, 1'b1, 1'b1);
    end
    // R4: oversize tail codes never cut, even with loop count zero
    for (int s = 4; s < 8; s++) begin
      apply(16'hFFFF, 4'h8, 4'h8, 3'(s), 32'd0, 4'h1, 3'd0);
      check("R4 oversize", 16'hFFFF, 1'b1, 1'b1);
    end
    // R3: large loop count with size 0 well above limit
    apply(16'hFFFF, 4'h8, 4'h8, 3'd0, 32'hFFFF_FFFF, 4'h0, 3'd0);
    check("R4 huge loop", 16'hFFFF, 1'b1, 1'b1);
    done = 1;
  end

  initial begin
    for (int k = 0; k < 5000 && !done; k++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule